// File: doc/BRIEF.md
# Colour-Map Load Port with Indexed Lookup

This block loads the colour map of an 8-bit indexed-colour display controller and serves that map to the pixel path. Software reaches it through two byte-addressed registers. One register selects the colour-map entry. The other takes colour data. The block keeps a red, a green and a blue table of 8-bit components, one entry for each index value. A component pointer cycles through red, green and blue. The pointer steps once for each data byte. When it wraps past blue, the entry index moves to the next entry.

The data register accepts a byte-wide write or a 32-bit write. A 32-bit write carries four components, taken from the top byte down to the bottom byte. It is absorbed in one bus cycle, even when it spans two entries, and the bus is never stalled.

The pixel path presents an index on a separate lookup port. One clock later it receives the packed 24-bit colour for that index. Every accepted data write raises a sticky redraw request, which the display side clears once it has repainted.

Top module: `palette_dac_wport`

## Requirements
- R1: After reset, every entry looks up as 0x000000, the component pointer is at red, the redraw request is high and bus read data is zero.
- R2: A write to offset 0x0 loads the entry index from wdata[7:0] and returns the component pointer to red, even when the previous entry is only partly written.
- R3: A byte write to offset 0x4 (bus_word = 0) stores wdata[7:0] into the red, green and blue components of the current entry, in that order on successive writes. Components that have not been written since reset stay zero.
- R4: Once the blue component has been stored, the index advances by one modulo 256 (entry 255 is followed by entry 0) and the pointer returns to red.
- R5: A 32-bit write to offset 0x4 (bus_word = 1) stores four components in one cycle, wdata[31:24] first and wdata[7:0] last. It continues from the current pointer position and may finish one entry and start the next. Writes on consecutive cycles are all accepted.
- R6: Every write to offset 0x4 sets redraw_pending. The redraw_clr input clears it, and a data write in the same cycle as redraw_clr leaves it set.
- R7: lk_rgb shows {red, green, blue} of the index sampled on lk_idx at the previous rising edge, with red in bits 23:16 and blue in bits 7:0.
- R8: A lookup of an entry in the same cycle as a write to that entry returns the value from before the write.
- R9: bus_rdata is zero after a read of either register. A write to any offset other than 0x0 and 0x4 changes neither the tables, the index, the pointer nor the redraw request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_word | input | 1 | 1 = 32-bit write, 0 = byte write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, always zero |
| redraw_clr | input | 1 | Display side acknowledges the redraw request |
| redraw_pending | output | 1 | Sticky redraw request |
| lk_idx | input | IDX_W | Lookup index from the pixel path |
| lk_rgb | output | 24 | Packed colour of the looked-up entry |

## Verification
The bench steers 32-bit writes into each of the three pointer positions. A design that mis-sequences the split bytes or fails to cross into the next entry would put components into the wrong table or the wrong entry. It drives the index through 255 to check the wrap to entry 0, and reloads the index while an entry is half written, which catches a pointer that is not reset. A lookup is issued in the same cycle as a write to the same entry, so a write-first memory would return the new colour too early. Writes to unmapped offsets, followed by a continued byte sequence, expose decoding that lets stray writes move the pointer or raise the redraw request.

// File: rtl/palette_dac_pkg.sv
package palette_dac_pkg;
  localparam int unsigned COMP_W   = 8;
  localparam int unsigned BUS_W    = 32;
  localparam int unsigned BUS_BYTES = BUS_W / COMP_W;
  localparam int unsigned NCOMP    = 3;
  localparam int unsigned NBANK    = NCOMP * 2;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phase_t;
endpackage

// File: rtl/palette_dac_bank.sv
module palette_dac_bank #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read-before-write: a same-cycle write is not visible on rdata
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/palette_dac_seq.sv
module palette_dac_seq
  import palette_dac_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic                              en,
  input  logic                              word,
  input  logic [BUS_W-1:0]                  wdata,
  input  logic [IDX_W-1:0]                  idx,
  input  phase_t                            phase,
  output logic [NBANK-1:0]                  bank_we,
  output logic [NBANK-1:0][IDX_W-2:0]       bank_addr,
  output logic [NBANK-1:0][COMP_W-1:0]      bank_data,
  output logic [IDX_W-1:0]                  nxt_idx,
  output phase_t                            nxt_phase
);
  logic [BUS_BYTES-1:0]             slot_en;
  logic [BUS_BYTES-1:0][2:0]        slot_pos;
  logic [BUS_BYTES-1:0]             slot_step;
  logic [BUS_BYTES-1:0][2:0]        slot_comp;
  logic [BUS_BYTES-1:0][IDX_W-1:0]  slot_ent;
  logic [BUS_BYTES-1:0][2:0]        slot_sel;
  logic [BUS_BYTES-1:0][COMP_W-1:0] slot_byte;

  // each byte slot lands at phase+k; two slots of one colour hit adjacent
  // entries, so they always fall into banks of opposite parity
  for (genvar k = 0; k < BUS_BYTES; k++) begin : g_slot
    assign slot_en[k]   = en && (word || (k == 0));
    assign slot_pos[k]  = {1'b0, phase} + 3'(k);
    assign slot_step[k] = (slot_pos[k] >= 3'd3);
    assign slot_comp[k] = slot_step[k] ? (slot_pos[k] - 3'd3) : slot_pos[k];
    assign slot_ent[k]  = idx + IDX_W'(slot_step[k]);
    assign slot_sel[k]  = {slot_comp[k][1:0], slot_ent[k][0]};
    assign slot_byte[k] = word ? wdata[BUS_W-1-COMP_W*k -: COMP_W]
                               : wdata[COMP_W-1:0];
  end

  always_comb begin
    bank_we   = '0;
    bank_addr = '0;
    bank_data = '0;
    for (int k = 0; k < BUS_BYTES; k++) begin
      if (slot_en[k]) begin
        bank_we[slot_sel[k]]   = 1'b1;
        bank_addr[slot_sel[k]] = slot_ent[k][IDX_W-1:1];
        bank_data[slot_sel[k]] = slot_byte[k];
      end
    end
  end

  logic [2:0] end_pos;
  logic [1:0] end_step;
  logic [2:0] end_comp;

  assign end_pos  = {1'b0, phase} + (word ? 3'(BUS_BYTES) : 3'd1);
  assign end_step = (end_pos >= 3'd6) ? 2'd2 : (end_pos >= 3'd3) ? 2'd1 : 2'd0;
  assign end_comp = end_pos - (3'd3 * {1'b0, end_step});
  assign nxt_idx   = idx + IDX_W'(end_step);
  assign nxt_phase = phase_t'(end_comp[1:0]);
endmodule

// File: rtl/palette_dac_wport.sv
module palette_dac_wport
  import palette_dac_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned OFS_INDEX = 0,
  parameter int unsigned OFS_DATA  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_word,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              redraw_clr,
  output logic              redraw_pending,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [23:0]       lk_rgb
);
  localparam int unsigned HA_W  = IDX_W - 1;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic wr_index, wr_data;
  assign wr_index = bus_we && (bus_addr == ADDR_W'(OFS_INDEX));
  assign wr_data  = bus_we && (bus_addr == ADDR_W'(OFS_DATA));

  logic [IDX_W-1:0] idx_q;
  phase_t           phase_q;

  logic [NBANK-1:0]             bank_we;
  logic [NBANK-1:0][HA_W-1:0]   bank_addr;
  logic [NBANK-1:0][COMP_W-1:0] bank_data;
  logic [NBANK-1:0][COMP_W-1:0] bank_rd;
  logic [IDX_W-1:0]             nxt_idx;
  phase_t                       nxt_phase;

  palette_dac_seq #(.IDX_W(IDX_W)) u_seq (
    .en        (wr_data),
    .word      (bus_word),
    .wdata     (bus_wdata),
    .idx       (idx_q),
    .phase     (phase_q),
    .bank_we   (bank_we),
    .bank_addr (bank_addr),
    .bank_data (bank_data),
    .nxt_idx   (nxt_idx),
    .nxt_phase (nxt_phase)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      phase_q <= PH_RED;
    end else if (wr_index) begin
      idx_q   <= bus_wdata[IDX_W-1:0];
      phase_q <= PH_RED;
    end else if (wr_data) begin
      idx_q   <= nxt_idx;
      phase_q <= nxt_phase;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 redraw_pending <= 1'b1;
    else if (wr_data)        redraw_pending <= 1'b1;
    else if (redraw_clr)     redraw_pending <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= '0;
  end

  // banks: slot s = colour*2 + index parity
  for (genvar s = 0; s < NBANK; s++) begin : g_bank
    palette_dac_bank #(.AW(HA_W), .DW(COMP_W)) u_bank (
      .clk   (clk),
      .we    (bank_we[s]),
      .waddr (bank_addr[s]),
      .wdata (bank_data[s]),
      .raddr (lk_idx[IDX_W-1:1]),
      .rdata (bank_rd[s])
    );
  end

  // per-component written flags stand in for clearing the RAMs at reset
  logic [DEPTH-1:0] written [NCOMP];
  logic [NCOMP-1:0] wr_vld_q;
  logic             lk_par_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCOMP; c++) written[c] <= '0;
      wr_vld_q <= '0;
      lk_par_q <= 1'b0;
    end else begin
      for (int s = 0; s < NBANK; s++) begin
        if (bank_we[s]) written[s / 2][{bank_addr[s], 1'(s % 2)}] <= 1'b1;
      end
      for (int c = 0; c < NCOMP; c++) wr_vld_q[c] <= written[c][lk_idx];
      lk_par_q <= lk_idx[0];
    end
  end

  for (genvar c = 0; c < NCOMP; c++) begin : g_out
    logic [COMP_W-1:0] comp_rd;
    assign comp_rd = lk_par_q ? bank_rd[2*c+1] : bank_rd[2*c];
    assign lk_rgb[(NCOMP-1-c)*COMP_W +: COMP_W] = wr_vld_q[c] ? comp_rd : '0;
  end
endmodule

// File: rtl/palette_dac_chk.sv
module palette_dac_chk #(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned OFS_INDEX = 0,
  parameter int unsigned OFS_DATA  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic              bus_word,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              redraw_pending,
  input logic [IDX_W-1:0]  idx_q,
  input logic [1:0]        phase_q
);
  logic idx_wr, dat_wr;
  assign idx_wr = bus_we && (bus_addr == ADDR_W'(OFS_INDEX));
  assign dat_wr = bus_we && (bus_addr == ADDR_W'(OFS_DATA));

  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (rst)
    idx_wr |=> (idx_q == $past(bus_wdata[IDX_W-1:0]) && phase_q == 2'd0))
    else $error("index load"); // R2

  AST_BYTE_PHASE: assert property (@(posedge clk) disable iff (rst)
    (dat_wr && !bus_word) |=>
      (phase_q == (($past(phase_q) == 2'd2) ? 2'd0 : $past(phase_q) + 2'd1)))
    else $error("byte phase step"); // R3

  AST_BLUE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (dat_wr && !bus_word && phase_q == 2'd2) |=>
      (idx_q == $past(idx_q) + IDX_W'(1)))
    else $error("index after blue"); // R4

  AST_WORD_STEP: assert property (@(posedge clk) disable iff (rst)
    (dat_wr && bus_word) |=>
      ((phase_q == (($past(phase_q) == 2'd2) ? 2'd0 : $past(phase_q) + 2'd1)) &&
       (idx_q == $past(idx_q) + (($past(phase_q) == 2'd2) ? IDX_W'(2) : IDX_W'(1)))))
    else $error("word step"); // R5

  AST_REDRAW_SET: assert property (@(posedge clk) disable iff (rst)
    dat_wr |=> redraw_pending)
    else $error("redraw request"); // R6
endmodule

bind palette_dac_wport palette_dac_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_INDEX(OFS_INDEX), .OFS_DATA(OFS_DATA)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .bus_we         (bus_we),
  .bus_word       (bus_word),
  .bus_addr       (bus_addr),
  .bus_wdata      (bus_wdata),
  .redraw_pending (redraw_pending),
  .idx_q          (idx_q),
  .phase_q        (phase_q)
);

// File: tb/palette_dac_wport_test.sv
`timescale 1ns/1ps
module palette_dac_wport_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0, bus_re = 1'b0, bus_word = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        redraw_clr = 1'b0;
  logic        redraw_pending;
  logic [7:0]  lk_idx = '0;
  logic [23:0] lk_rgb;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  logic [23:0] exp_rgb [256];
  logic [7:0]  m_idx;
  int          m_ph;

  always #4 clk = ~clk;

  palette_dac_wport uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_word(bus_word), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .redraw_clr(redraw_clr),
    .redraw_pending(redraw_pending), .lk_idx(lk_idx), .lk_rgb(lk_rgb)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic void model_put(logic [7:0] b);
    case (m_ph)
      0: exp_rgb[m_idx][23:16] = b;
      1: exp_rgb[m_idx][15:8]  = b;
      default: exp_rgb[m_idx][7:0] = b;
    endcase
    if (m_ph == 2) begin m_ph = 0; m_idx = m_idx + 8'd1; end
    else m_ph++;
  endfunction

  task automatic wr_index(logic [7:0] v);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 5'h0; bus_word = 1'b0; bus_wdata = {24'h0, v};
    @(negedge clk);
    bus_we = 1'b0;
    m_idx = v; m_ph = 0;
  endtask

  task automatic wr_byte(logic [7:0] v);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 5'h4; bus_word = 1'b0; bus_wdata = {24'hABCDEF, v};
    @(negedge clk);
    bus_we = 1'b0;
    model_put(v);
  endtask

  task automatic wr_word(logic [31:0] v);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 5'h4; bus_word = 1'b1; bus_wdata = v;
    @(negedge clk);
    bus_we = 1'b0;
    for (int k = 3; k >= 0; k--) model_put(v[8*k +: 8]);
  endtask

  task automatic lookup(logic [7:0] i, output logic [23:0] got);
    @(negedge clk);
    lk_idx = i;
    @(negedge clk);
    got = lk_rgb;
  endtask

  task automatic check_entry(string req, logic [7:0] i);
    logic [23:0] got;
    lookup(i, got);
    check(req, {8'h0, got}, {8'h0, exp_rgb[i]});
  endtask

  task automatic t_reset;
    check("R1 redraw after reset", {31'h0, redraw_pending}, 32'h1);
    check("R1 rdata after reset", bus_rdata, 32'h0);
    check_entry("R1 entry 0", 8'd0);
    check_entry("R1 entry 128", 8'd128);
    check_entry("R1 entry 255", 8'd255);
  endtask

  task automatic t_bytes;
    logic [23:0] got;
    wr_index(8'd5);
    wr_byte(8'h11); wr_byte(8'h22); wr_byte(8'h33);
    wr_byte(8'h44);
    lookup(8'd5, got);
    check("R3 entry 5 rgb", {8'h0, got}, 32'h00112233);
    lookup(8'd6, got);
    check("R4 entry 6 red only", {8'h0, got}, 32'h00440000);
  endtask

  task automatic t_wrap;
    logic [23:0] got;
    wr_index(8'd255);
    wr_byte(8'hA0); wr_byte(8'hA1); wr_byte(8'hA2);
    wr_byte(8'h5A);
    lookup(8'd255, got);
    check("R4 entry 255", {8'h0, got}, 32'h00A0A1A2);
    lookup(8'd0, got);
    check("R4 wrap to entry 0", {8'h0, got}, 32'h005A0000);
  endtask

  task automatic t_words;
    logic [23:0] got;
    wr_index(8'd10);
    wr_word(32'hA1B2C3D4);
    wr_word(32'h01020304);
    wr_word(32'h05060708);
    lookup(8'd10, got); check("R5 word from red", {8'h0, got}, 32'h00A1B2C3);
    lookup(8'd11, got); check("R5 word from green", {8'h0, got}, 32'h00D40102);
    lookup(8'd12, got); check("R5 word from blue", {8'h0, got}, 32'h00030405);
    lookup(8'd13, got); check("R5 word crossing", {8'h0, got}, 32'h00060708);
    wr_byte(8'h99);
    check_entry("R5 pointer after words", 8'd14);
  endtask

  task automatic t_burst;
    wr_index(8'd40);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 5'h4; bus_word = 1'b1;
    for (int n = 0; n < 3; n++) begin
      bus_wdata = 32'h10203040 + 32'h01010101 * n;
      for (int k = 3; k >= 0; k--) model_put(bus_wdata[8*k +: 8]);
      @(negedge clk);
    end
    bus_we = 1'b0;
    for (int e = 40; e < 44; e++) check_entry("R5 back-to-back words", 8'(e));
  endtask

  task automatic t_reindex;
    logic [23:0] got;
    wr_index(8'd20);
    wr_byte(8'h77);
    wr_index(8'd20);
    wr_byte(8'h88);
    lookup(8'd20, got);
    check("R2 reload resets pointer", {8'h0, got}, 32'h00880000);
  endtask

  task automatic t_redraw;
    @(negedge clk); redraw_clr = 1'b1;
    @(negedge clk); redraw_clr = 1'b0;
    check("R6 cleared", {31'h0, redraw_pending}, 32'h0);
    wr_index(8'd60);
    check("R6 index write no redraw", {31'h0, redraw_pending}, 32'h0);
    wr_byte(8'h01);
    check("R6 set by data write", {31'h0, redraw_pending}, 32'h1);
    @(negedge clk); redraw_clr = 1'b1;
    @(negedge clk); redraw_clr = 1'b0;
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 5'h4; bus_word = 1'b0; bus_wdata = 32'h02; redraw_clr = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; redraw_clr = 1'b0;
    model_put(8'h02);
    check("R6 write beats clear", {31'h0, redraw_pending}, 32'h1);
  endtask

  task automatic t_ignore;
    wr_index(8'd50);
    wr_byte(8'h11);
    @(negedge clk); redraw_clr = 1'b1;
    @(negedge clk); redraw_clr = 1'b0;
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 5'h8; bus_word = 1'b0; bus_wdata = 32'hFF;
    @(negedge clk);
    bus_addr = 5'h10; bus_word = 1'b1; bus_wdata = 32'hDEADBEEF;
    @(negedge clk);
    bus_we = 1'b0;
    check("R9 stray write no redraw", {31'h0, redraw_pending}, 32'h0);
    wr_byte(8'h22);
    check_entry("R9 entry 50 after stray", 8'd50);
    check_entry("R9 entry 51 untouched", 8'd51);
    @(negedge clk); bus_re = 1'b1; bus_addr = 5'h0;
    @(negedge clk); bus_addr = 5'h4;
    check("R9 read index reg", bus_rdata, 32'h0);
    @(negedge clk); bus_re = 1'b0;
    check("R9 read data reg", bus_rdata, 32'h0);
  endtask

  task automatic t_collide;
    logic [23:0] got;
    wr_index(8'd30);
    @(negedge clk);
    lk_idx = 8'd30;
    bus_we = 1'b1; bus_addr = 5'h4; bus_word = 1'b0; bus_wdata = 32'hC3;
    @(negedge clk);
    bus_we = 1'b0;
    check("R8 same-cycle lookup old", {8'h0, lk_rgb}, 32'h0);
    model_put(8'hC3);
    lookup(8'd30, got);
    check("R8 later lookup new", {8'h0, got}, 32'h00C30000);
  endtask

  task automatic t_latency;
    @(negedge clk); lk_idx = 8'd5;
    @(negedge clk);
    check("R7 packing entry 5", {8'h0, lk_rgb}, {8'h0, exp_rgb[5]});
    lk_idx = 8'd10;
    #2;
    check("R7 one-cycle latency hold", {8'h0, lk_rgb}, {8'h0, exp_rgb[5]});
    @(negedge clk);
    check("R7 after edge", {8'h0, lk_rgb}, {8'h0, exp_rgb[10]});
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) exp_rgb[i] = '0;
    m_idx = '0; m_ph = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_bytes();
    t_wrap();
    t_words();
    t_burst();
    t_reindex();
    t_redraw();
    t_ignore();
    t_collide();
    t_latency();
    finish_run();
  end

  initial begin
    #(200000 * 8);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule